// File: doc/BRIEF.md
# Persistent Register Bank Store Sequencer

This block holds sixteen six-bit persistent setting registers, four for each of four channels, and decides when a store into them takes place. A command decoder in front of it hands over one store request per serial frame. A request is one of three kinds: a data value from the host for one register, a copy of one channel's wiper into one of that channel's registers, or a copy of every channel's wiper into the register with the same index in each channel. The decoder then signals that the frame's final byte is complete. The store is carried out only on the rising edge of chip select that follows.

Each accepted store starts a timed write cycle. During that cycle a busy flag is raised, so that the serial status command can report it, and further store requests are refused. A hardware protect input, active low, blocks every store. Any register can be read combinationally at any time, including during a write cycle. After reset the registers hold a parameter value, which stands in for contents kept across power cycles.

Top module: `nv_store_bank`

## Requirements
- R1: After reset every register k (k = channel*4 + index) holds bits [6k+5:6k] of the INIT_VALUE parameter and `busy` is low.
- R2: A host write (`req_op` = 0) loads `req_data` into the register chosen by `req_chan`/`req_idx`. The register keeps its old value while `cs_n` is low and takes the new value on the clock edge at which `cs_n` is first sampled high.
- R3: A single transfer (`req_op` = 1) stores the wiper of `req_chan`, taken from `wiper` bits [6c+5:6c] at the edge where `cs_n` rises, into register `req_idx` of that channel only.
- R4: A global transfer (`req_op` = 2) stores each channel's wiper into that channel's register `req_idx`. All four registers change on the same edge.
- R5: If `cs_n` rises before `frame_done` has been seen for the pending request, the request is discarded, and a later `cs_n` rise stores nothing.
- R6: A store raises `busy` on the edge that commits it. `busy` then stays high for exactly WR_CYCLES clock cycles.
- R7: If `wp_n` is low when `cs_n` rises, nothing is stored and `busy` stays low.
- R8: Requests, frame completions and `cs_n` rises that occur while `busy` is high change no register and do not restart or extend the write cycle.
- R9: `rd_data` always shows the register chosen by `rd_chan`/`rd_idx`, including while `busy` is high.
- R10: A store changes no register other than the ones its kind selects.
- R11: A request with `req_op` = 3 is ignored: no register changes and `busy` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low, synchronous to clk |
| wp_n | input | 1 | Store protect, low blocks all stores |
| req_valid | input | 1 | One-cycle pulse carrying a store request |
| req_op | input | 2 | 0 host write, 1 single transfer, 2 global transfer, 3 reserved |
| req_chan | input | 2 | Channel for host write and single transfer |
| req_idx | input | 2 | Register index within a channel |
| req_data | input | 6 | Host data for a host write |
| frame_done | input | 1 | Pulse: final byte of the frame received |
| wiper | input | 24 | Current wiper of each channel, 6 bits per channel |
| rd_chan | input | 2 | Read channel select |
| rd_idx | input | 2 | Read register select |
| rd_data | output | 6 | Selected register contents |
| busy | output | 1 | Write cycle in progress |

## Verification
The hardest case to reach is a complete and valid-looking frame that ends while a write cycle is still running. This needs a second chip-select pulse with a request, a frame completion and a rising edge, all inside the busy window of the first store. The bench keeps WR_CYCLES short and sends this frame right after a commit. It then confirms that no register moved and that the busy window ends on the original count. The aborted-frame case is reached by raising chip select without the completion pulse and then sending a bare select pulse afterwards.

// File: rtl/nv_store_bank.sv
module nv_store_bank #(
  parameter int CH = 4,
  parameter int REGS = 4,
  parameter int W = 6,
  parameter int WR_CYCLES = 500000,
  parameter logic [CH*REGS*W-1:0] INIT_VALUE = '0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cs_n,
  input  logic                      wp_n,
  input  logic                      req_valid,
  input  logic [1:0]                req_op,
  input  logic [$clog2(CH)-1:0]     req_chan,
  input  logic [$clog2(REGS)-1:0]   req_idx,
  input  logic [W-1:0]              req_data,
  input  logic                      frame_done,
  input  logic [CH*W-1:0]           wiper,
  input  logic [$clog2(CH)-1:0]     rd_chan,
  input  logic [$clog2(REGS)-1:0]   rd_idx,
  output logic [W-1:0]              rd_data,
  output logic                      busy
);
  localparam int CHW = $clog2(CH);
  localparam int IW  = $clog2(REGS);
  localparam int CW  = $clog2(WR_CYCLES + 1);
  localparam logic [1:0] OP_HOST = 2'd0;
  localparam logic [1:0] OP_ONE  = 2'd1;
  localparam logic [1:0] OP_ALL  = 2'd2;

  logic [CH*REGS*W-1:0] store;
  logic [CW-1:0]        cnt;
  logic                 cs_q, pend, armed;
  logic [1:0]           op_q;
  logic [CHW-1:0]       ch_q;
  logic [IW-1:0]        idx_q;
  logic [W-1:0]         data_q;

  wire cs_rise = cs_n & ~cs_q;
  wire commit  = cs_rise & pend & armed & wp_n & ~busy;
  wire take    = req_valid & ~busy & ~cs_n & (req_op != 2'd3);

  assign busy    = (cnt != '0);
  assign rd_data = store[(int'(rd_chan) * REGS + int'(rd_idx)) * W +: W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 1'b1;
      pend   <= 1'b0;
      armed  <= 1'b0;
      op_q   <= '0;
      ch_q   <= '0;
      idx_q  <= '0;
      data_q <= '0;
    end else begin
      cs_q <= cs_n;
      if (cs_rise) begin
        pend  <= 1'b0;
        armed <= 1'b0;
      end else begin
        if (take) begin
          pend   <= 1'b1;
          armed  <= 1'b0;
          op_q   <= req_op;
          ch_q   <= req_chan;
          idx_q  <= req_idx;
          data_q <= req_data;
        end else if (frame_done && pend && !busy) begin
          armed <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (commit)
      cnt <= CW'(WR_CYCLES);
    else if (busy)
      cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store <= INIT_VALUE;
    end else if (commit) begin
      for (int c = 0; c < CH; c++) begin
        for (int r = 0; r < REGS; r++) begin
          if (r == int'(idx_q) && (op_q == OP_ALL || ((op_q == OP_HOST || op_q == OP_ONE) && c == int'(ch_q))))
            store[(c * REGS + r) * W +: W] <= (op_q == OP_HOST) ? data_q : wiper[c * W +: W];
        end
      end
    end
  end

  a_r6_busy_on_commit: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && pend && armed && wp_n && !busy) |=> busy);

  a_r7_protect_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !wp_n && !busy) |=> (!busy && $stable(store)));

  a_r8_frozen_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(store));

  a_r5_no_store_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !armed) |=> $stable(store));

  a_r8_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: tb/tb_nv_store_bank.sv
`timescale 1ns/10ps
module tb_nv_store_bank;
  localparam int WRC = 12;

  function automatic logic [95:0] mk_init();
    logic [95:0] v;
    for (int k = 0; k < 16; k++) v[k*6 +: 6] = 6'((k * 11 + 3) & 63);
    return v;
  endfunction
  localparam logic [95:0] INITV = mk_init();

  logic clk = 0, rst_n = 0, cs_n = 1, wp_n = 1, req_valid = 0, frame_done = 0;
  logic [1:0] req_op = 0, req_chan = 0, req_idx = 0, rd_chan = 0, rd_idx = 0;
  logic [5:0] req_data = 0, rd_data;
  logic [23:0] wiper = 0;
  logic busy;

  nv_store_bank #(.WR_CYCLES(WRC), .INIT_VALUE(INITV)) dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wp_n(wp_n), .req_valid(req_valid),
    .req_op(req_op), .req_chan(req_chan), .req_idx(req_idx), .req_data(req_data),
    .frame_done(frame_done), .wiper(wiper), .rd_chan(rd_chan), .rd_idx(rd_idx),
    .rd_data(rd_data), .busy(busy));

  always #2 clk = ~clk;

  int checks = 0, errors = 0, done = 0;
  logic [5:0] expv [16];

  // {op, chan, idx, data}
  localparam logic [11:0] VEC [8] = '{
    {2'd0, 2'd1, 2'd2, 6'h2A}, {2'd0, 2'd3, 2'd0, 6'h3F}, {2'd1, 2'd2, 2'd3, 6'h05},
    {2'd2, 2'd0, 2'd1, 6'h11}, {2'd0, 2'd0, 2'd0, 6'h00}, {2'd1, 2'd0, 2'd0, 6'h3E},
    {2'd2, 2'd3, 2'd3, 6'h20}, {2'd0, 2'd2, 2'd1, 6'h15}};

  function automatic logic [5:0] wip(input int c, input logic [5:0] d);
    return 6'((int'(d) + 5 * c + 1) & 63);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all(input string req);
    int bad = 0, fa = 0, fe = 0;
    for (int k = 0; k < 16; k++) begin
      rd_chan = 2'(k / 4); rd_idx = 2'(k % 4);
      #0.1;
      if (rd_data !== expv[k] && bad == 0) begin fa = int'(rd_data); fe = int'(expv[k]); end
      if (rd_data !== expv[k]) bad++;
    end
    chk(bad == 0, req, fa, fe);
  endtask

  task automatic frame(input logic [1:0] op, input logic [1:0] ch, input logic [1:0] idx,
                       input logic [5:0] d, input bit complete);
    @(negedge clk); cs_n = 0;
    @(negedge clk); req_valid = 1; req_op = op; req_chan = ch; req_idx = idx; req_data = d;
    @(negedge clk); req_valid = 0;
    if (complete) begin @(negedge clk); frame_done = 1; @(negedge clk); frame_done = 0; end
    @(negedge clk); cs_n = 1;
    @(negedge clk);
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy === 1'b1 && n < 10 * WRC) begin n++; @(negedge clk); end
  endtask

  initial begin
    int n;
    for (int k = 0; k < 16; k++) expv[k] = INITV[k*6 +: 6];
    #5; rst_n = 1;
    @(negedge clk);
    chk(busy === 1'b0, "R1 busy after reset", int'(busy), 0);
    check_all("R1 reset contents");

    for (int v = 0; v < 8; v++) begin
      logic [1:0] op, ch, ix; logic [5:0] d;
      {op, ch, ix, d} = VEC[v];
      for (int c = 0; c < 4; c++) wiper[c*6 +: 6] = wip(c, d);
      // R2 unchanged while cs low: check mid-frame
      @(negedge clk); cs_n = 0;
      @(negedge clk); req_valid = 1; req_op = op; req_chan = ch; req_idx = ix; req_data = d;
      @(negedge clk); req_valid = 0; frame_done = 1;
      @(negedge clk); frame_done = 0;
      check_all("R2 no store while cs low");
      cs_n = 1;
      @(negedge clk);
      if (op == 2'd0) expv[ch*4+ix] = d;
      else if (op == 2'd1) expv[ch*4+ix] = wip(int'(ch), d);
      else for (int c = 0; c < 4; c++) expv[c*4+ix] = wip(c, d);
      check_all(op == 0 ? "R2 host write R10" : op == 1 ? "R3 single transfer R10" : "R4 global transfer R10");
      count_busy(n);
      chk(n == WRC, "R6 busy length", n, WRC);
    end

    // R9 read during busy, R8 frame during busy ignored
    wiper = 24'h0;
    frame(2'd0, 2'd1, 2'd1, 6'h33, 1);
    expv[5] = 6'h33;
    chk(busy === 1'b1, "R6 busy raised", int'(busy), 1);
    rd_chan = 2'd1; rd_idx = 2'd1; #0.1;
    chk(rd_data === 6'h33, "R9 read while busy", int'(rd_data), 'h33);
    frame(2'd0, 2'd1, 2'd1, 6'h01, 1);
    count_busy(n);
    chk(n == WRC - 7, "R8 no restart", n, WRC - 7);
    check_all("R8 ignored while busy");

    // R5 aborted frame then bare select pulse
    frame(2'd0, 2'd2, 2'd2, 6'h07, 0);
    chk(busy === 1'b0, "R5 no busy on abort", int'(busy), 0);
    @(negedge clk); cs_n = 0; @(negedge clk); frame_done = 1; @(negedge clk); frame_done = 0;
    @(negedge clk); cs_n = 1; @(negedge clk);
    chk(busy === 1'b0, "R5 later rise", int'(busy), 0);
    check_all("R5 discarded");

    // R7 protect
    wp_n = 0;
    frame(2'd2, 2'd0, 2'd0, 6'h09, 1);
    chk(busy === 1'b0, "R7 no busy protected", int'(busy), 0);
    check_all("R7 protected");
    wp_n = 1;

    // R11 reserved op
    frame(2'd3, 2'd0, 2'd0, 6'h09, 1);
    chk(busy === 1'b0, "R11 reserved no busy", int'(busy), 0);
    check_all("R11 reserved ignored");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (done == 0) begin
      checks++; errors++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule